// File: doc/BRIEF.md
# UART Register and Interrupt Control Block

This block sits between a 32-bit register port and the serial engine of a UART. It decodes a small register space: three plain configuration words (control, frame format, clock divider) that are handed to the serial engine, a command word whose bits are one-cycle pulses that switch the transmitter and receiver on or off, a live status word, and an interrupt flag word with its own set, clear and enable words. Two interrupt lines leave the block, one for receive events and one for transmit events.

Characters arriving from the serial engine are held in a small receive buffer. Software drains it by reading the receive-data word. Characters written by software go into a two-entry transmit buffer, and the serial engine takes them one at a time. The transmit side is run by a three-state machine: OFF (disabled), IDLE (enabled, no frame on the wire) and BUSY (one frame being shifted). Its transitions are: OFF to IDLE on an enable command; IDLE to BUSY when the engine takes a character; BUSY to IDLE when the engine reports the frame done; and any state to OFF on a disable command. The receive side has two states, RX_OFF and RX_ON. RX_OFF goes to RX_ON on an enable command, and RX_ON goes to RX_OFF on a disable command.

The threshold for the transmit buffer level is chosen by control bit 12. When it is clear, the level condition means the buffer is empty. When it is set, the condition means at least one entry is free. The level is never stored: it always follows the current buffer state.

Top module: `uart_regblk`

## Requirements
- R1: After reset both directions are disabled, both buffers are empty, all stored flags, enables and configuration words are zero, so status reads 0x40 and the flag word reads 0x2.
- R2: A write to command offset 0x0C acts for one cycle only. Bit 0 turns the receiver on, bit 1 turns it off, bit 2 turns the transmitter on and bit 3 turns it off. If on and off are both set, off wins. The new state appears on rx_en/tx_en and in status bit 1 from the next cycle. The command word reads as 0.
- R3: The words at offsets 0x00 (control), 0x04 (frame) and 0x14 (clock divider) store all 32 bits written, read back unchanged, and drive cfg_ctrl, cfg_frame and cfg_clkdiv.
- R4: While the receiver is on, rx_push stores rx_char in the receive buffer (RX_DEPTH entries) and sets flag bit 2. If the buffer is already full, the character is dropped and flag bit 4 is set. While the receiver is off, rx_push has no effect.
- R5: A read of offset 0x18 returns the oldest received character in bits 8:0 and removes it from the buffer. A read when the buffer is empty returns 0 and changes nothing. Status bit 7 is 1 while the buffer holds data.
- R6: A write to offset 0x34 appends bits 8:0 to the transmit buffer (two entries). The write is dropped when the buffer is full. Every such write clears status bit 5.
- R7: tx_avail is 1 only in IDLE with a non-empty buffer, and tx_char is then the oldest entry. tx_pop in that case removes the entry and enters BUSY. tx_done in BUSY returns to IDLE. If the buffer is empty at that moment, status bit 5 and flag bit 0 are set. A disable command drops the block to OFF, and a later tx_done is ignored.
- R8: Status bit 6 and flag bit 1 both show the transmit level condition: buffer empty when control bit 12 is 0, fewer than two entries when it is 1. Writes to set (0x44) or clear (0x48) have no effect on flag bit 1.
- R9: Writing ones to 0x44 sets, and to 0x48 clears, exactly those flag bits among 0, 2 and 4. All other bits are unchanged. A hardware event in the same cycle as a clear leaves the flag set. Both words read as 0.
- R10: The enable word at 0x4C reads back as written. irq_rx is the OR of enabled flag bits 2 and 4. irq_tx is the OR of enabled flag bits 0 and 1.
- R11: Unmapped offsets read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle, 0 when not reading |
| rx_push | input | 1 | Serial engine delivers a character |
| rx_char | input | DATA_W | Received character |
| tx_pop | input | 1 | Serial engine takes the offered character |
| tx_done | input | 1 | Serial engine finished the current frame |
| tx_avail | output | 1 | A character is offered to the serial engine |
| tx_char | output | DATA_W | Offered character |
| rx_en | output | 1 | Receiver enabled |
| tx_en | output | 1 | Transmitter enabled |
| cfg_ctrl | output | 32 | Control word |
| cfg_frame | output | 32 | Frame format word |
| cfg_clkdiv | output | 32 | Clock divider word |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
Read data is combinational, so a read result is due in the cycle the access is presented. A pop caused by that read shows only in the next cycle. Writes, commands, pushes, pops and frame-done pulses all take effect at the clock edge that ends their cycle. Status, flags, enables, tx_avail and both interrupt lines therefore change exactly one cycle later. The bench drives inputs just after a rising edge and compares every output against its queue-based model at the falling edge. At that point the model already holds the state from all earlier edges and sees the same pending inputs as the design.

// File: rtl/uart_regblk_pkg.sv
`timescale 1ns/1ps
package uart_regblk_pkg;
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_FRAME  = 8'h04;
    localparam logic [7:0] OFS_CMD    = 8'h0C;
    localparam logic [7:0] OFS_STAT   = 8'h10;
    localparam logic [7:0] OFS_CLKDIV = 8'h14;
    localparam logic [7:0] OFS_RXD    = 8'h18;
    localparam logic [7:0] OFS_TXD    = 8'h34;
    localparam logic [7:0] OFS_FLAG   = 8'h40;
    localparam logic [7:0] OFS_FSET   = 8'h44;
    localparam logic [7:0] OFS_FCLR   = 8'h48;
    localparam logic [7:0] OFS_FEN    = 8'h4C;

    localparam int CMD_RXON  = 0;
    localparam int CMD_RXOFF = 1;
    localparam int CMD_TXON  = 2;
    localparam int CMD_TXOFF = 3;

    localparam int ST_TXON   = 1;
    localparam int ST_TXDONE = 5;
    localparam int ST_TXROOM = 6;
    localparam int ST_RXVAL  = 7;

    localparam int FL_TXDONE = 0;
    localparam int FL_TXLVL  = 1;
    localparam int FL_RXVAL  = 2;
    localparam int FL_RXOVF  = 4;

    localparam int CTRL_LVLSEL = 12;

    typedef enum logic [1:0] {TX_OFF, TX_IDLE, TX_BUSY} tx_state_t;
    typedef enum logic {RX_OFF, RX_ON} rx_state_t;
endpackage

// File: rtl/ureg_fifo.sv
`timescale 1ns/1ps
module ureg_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [W-1:0]  slot [DEPTH];
    logic          push_ok, pop_ok;

    assign push_ok = push && (count != CW'(DEPTH));
    assign pop_ok  = pop && (count != '0);
    assign empty   = (count == '0);
    assign head    = slot[rd_ptr];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= wrap_inc(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && wr_ptr == PW'(i)) slot[i] <= wdata;
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_drop_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && push && !pop) |=> count == CW'(DEPTH));
endmodule

// File: rtl/ureg_rxctl.sv
`timescale 1ns/1ps
module ureg_rxctl
    import uart_regblk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_on,
    input  logic cmd_off,
    input  logic push,
    input  logic buf_full,
    output logic rx_on,
    output logic store,
    output logic overflow
);
    rx_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_OFF: if (cmd_on && !cmd_off) state_d = RX_ON;
            RX_ON:  if (cmd_off)            state_d = RX_OFF;
            default: state_d = RX_OFF;
        endcase
    end

    always_comb begin
        rx_on    = (state_q == RX_ON);
        store    = rx_on && push && !buf_full;
        overflow = rx_on && push && buf_full;
    end

    assert_off_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_off |=> !rx_on);
endmodule

// File: rtl/ureg_txctl.sv
`timescale 1ns/1ps
module ureg_txctl
    import uart_regblk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_on,
    input  logic      cmd_off,
    input  logic      buf_empty,
    input  logic      pop_req,
    input  logic      done_in,
    output tx_state_t state,
    output logic      pop_ok,
    output logic      complete
);
    tx_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cmd_off) begin
            state_d = TX_OFF;
        end else begin
            unique case (state_q)
                TX_OFF:  if (cmd_on)                 state_d = TX_IDLE;
                TX_IDLE: if (pop_req && !buf_empty)  state_d = TX_BUSY;
                TX_BUSY: if (done_in)                state_d = TX_IDLE;
                default:                             state_d = TX_OFF;
            endcase
        end
    end

    always_comb begin
        state    = state_q;
        pop_ok   = (state_q == TX_IDLE) && pop_req && !buf_empty && !cmd_off;
        complete = (state_q == TX_BUSY) && done_in && buf_empty && !cmd_off;
    end

    assert_take_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && pop_req && !buf_empty && !cmd_off) |=> state_q == TX_BUSY);
    assert_done_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_OFF && !cmd_on) |=> state_q == TX_OFF);
endmodule

// File: rtl/ureg_irq.sv
`timescale 1ns/1ps
module ureg_irq
    import uart_regblk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_we,
    input  logic        clr_we,
    input  logic        en_we,
    input  logic [31:0] wdata,
    input  logic        ev_txdone,
    input  logic        ev_rxval,
    input  logic        ev_rxovf,
    input  logic        lvl,
    output logic [31:0] flag_view,
    output logic [31:0] ien_q,
    output logic        irq_rx,
    output logic        irq_tx
);
    localparam logic [31:0] STORED = (32'd1 << FL_TXDONE) | (32'd1 << FL_RXVAL) | (32'd1 << FL_RXOVF);
    localparam logic [31:0] RX_SRC = (32'd1 << FL_RXVAL) | (32'd1 << FL_RXOVF);
    localparam logic [31:0] TX_SRC = (32'd1 << FL_TXDONE) | (32'd1 << FL_TXLVL);

    logic [31:0] stored_q, stored_d, events;

    always_comb begin
        events = '0;
        events[FL_TXDONE] = ev_txdone;
        events[FL_RXVAL]  = ev_rxval;
        events[FL_RXOVF]  = ev_rxovf;
        stored_d = stored_q;
        if (set_we) stored_d = stored_d | (wdata & STORED);
        if (clr_we) stored_d = stored_d & ~(wdata & STORED);
        stored_d = stored_d | events;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored_q <= '0;
            ien_q    <= '0;
        end else begin
            stored_q <= stored_d;
            if (en_we) ien_q <= wdata;
        end
    end

    always_comb begin
        flag_view = stored_q;
        flag_view[FL_TXLVL] = lvl;
        irq_rx = |(flag_view & ien_q & RX_SRC);
        irq_tx = |(flag_view & ien_q & TX_SRC);
    end

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && wdata[FL_RXOVF] && !ev_rxovf) |=> !flag_view[FL_RXOVF]);
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rxval |=> flag_view[FL_RXVAL]);
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && wdata == 32'd0) |=> (!irq_rx && !irq_tx));
endmodule

// File: rtl/uart_regblk.sv
`timescale 1ns/1ps
module uart_regblk
    import uart_regblk_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 9,
    parameter int RX_DEPTH = 2,
    parameter int TX_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              tx_pop,
    input  logic              tx_done,
    output logic              tx_avail,
    output logic [DATA_W-1:0] tx_char,
    output logic              rx_en,
    output logic              tx_en,
    output logic [31:0]       cfg_ctrl,
    output logic [31:0]       cfg_frame,
    output logic [31:0]       cfg_clkdiv,
    output logic              irq_rx,
    output logic              irq_tx
);
    localparam int RXCW = $clog2(RX_DEPTH + 1);
    localparam int TXCW = $clog2(TX_DEPTH + 1);

    logic wr_acc, rd_acc;
    logic wr_ctrl, wr_frame, wr_cmd, wr_clkdiv, wr_txd, wr_fset, wr_fclr, wr_fen, rd_rxd;
    logic cmd_rxon, cmd_rxoff, cmd_txon, cmd_txoff;

    assign wr_acc    = reg_sel && reg_wr;
    assign rd_acc    = reg_sel && !reg_wr;
    assign wr_ctrl   = wr_acc && reg_addr == ADDR_W'(OFS_CTRL);
    assign wr_frame  = wr_acc && reg_addr == ADDR_W'(OFS_FRAME);
    assign wr_cmd    = wr_acc && reg_addr == ADDR_W'(OFS_CMD);
    assign wr_clkdiv = wr_acc && reg_addr == ADDR_W'(OFS_CLKDIV);
    assign wr_txd    = wr_acc && reg_addr == ADDR_W'(OFS_TXD);
    assign wr_fset   = wr_acc && reg_addr == ADDR_W'(OFS_FSET);
    assign wr_fclr   = wr_acc && reg_addr == ADDR_W'(OFS_FCLR);
    assign wr_fen    = wr_acc && reg_addr == ADDR_W'(OFS_FEN);
    assign rd_rxd    = rd_acc && reg_addr == ADDR_W'(OFS_RXD);

    assign cmd_rxon  = wr_cmd && reg_wdata[CMD_RXON];
    assign cmd_rxoff = wr_cmd && reg_wdata[CMD_RXOFF];
    assign cmd_txon  = wr_cmd && reg_wdata[CMD_TXON];
    assign cmd_txoff = wr_cmd && reg_wdata[CMD_TXOFF];

    // configuration words
    logic [31:0] ctrl_q, frame_q, clkdiv_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            frame_q  <= '0;
            clkdiv_q <= '0;
        end else begin
            if (wr_ctrl)   ctrl_q   <= reg_wdata;
            if (wr_frame)  frame_q  <= reg_wdata;
            if (wr_clkdiv) clkdiv_q <= reg_wdata;
        end
    end
    assign cfg_ctrl   = ctrl_q;
    assign cfg_frame  = frame_q;
    assign cfg_clkdiv = clkdiv_q;

    // receive path
    logic [DATA_W-1:0] rx_head;
    logic [RXCW-1:0]   rx_cnt;
    logic              rx_empty, rx_store, rx_ovf;

    ureg_rxctl u_rxctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_on   (cmd_rxon),
        .cmd_off  (cmd_rxoff),
        .push     (rx_push),
        .buf_full (rx_cnt == RXCW'(RX_DEPTH)),
        .rx_on    (rx_en),
        .store    (rx_store),
        .overflow (rx_ovf)
    );

    ureg_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_store),
        .wdata (rx_char),
        .pop   (rd_rxd),
        .head  (rx_head),
        .count (rx_cnt),
        .empty (rx_empty)
    );

    // transmit path
    logic [DATA_W-1:0] tx_head;
    logic [TXCW-1:0]   tx_cnt;
    logic              tx_empty, tx_take, tx_complete, txc_q, lvl;
    tx_state_t         tx_state;

    ureg_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_txd),
        .wdata (reg_wdata[DATA_W-1:0]),
        .pop   (tx_take),
        .head  (tx_head),
        .count (tx_cnt),
        .empty (tx_empty)
    );

    ureg_txctl u_txctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_on    (cmd_txon),
        .cmd_off   (cmd_txoff),
        .buf_empty (tx_empty),
        .pop_req   (tx_pop),
        .done_in   (tx_done),
        .state     (tx_state),
        .pop_ok    (tx_take),
        .complete  (tx_complete)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           txc_q <= 1'b0;
        else if (wr_txd)      txc_q <= 1'b0;
        else if (tx_complete) txc_q <= 1'b1;
    end

    assign lvl      = ctrl_q[CTRL_LVLSEL] ? (tx_cnt < TXCW'(TX_DEPTH)) : tx_empty;
    assign tx_en    = (tx_state != TX_OFF);
    assign tx_avail = (tx_state == TX_IDLE) && !tx_empty;
    assign tx_char  = tx_empty ? '0 : tx_head;

    // interrupt flags
    logic [31:0] flag_view, ien_q;
    ureg_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_we    (wr_fset),
        .clr_we    (wr_fclr),
        .en_we     (wr_fen),
        .wdata     (reg_wdata),
        .ev_txdone (tx_complete),
        .ev_rxval  (rx_store),
        .ev_rxovf  (rx_ovf),
        .lvl       (lvl),
        .flag_view (flag_view),
        .ien_q     (ien_q),
        .irq_rx    (irq_rx),
        .irq_tx    (irq_tx)
    );

    // read mux
    logic [31:0] status;
    always_comb begin
        status = '0;
        status[ST_TXON]   = tx_en;
        status[ST_TXDONE] = txc_q;
        status[ST_TXROOM] = lvl;
        status[ST_RXVAL]  = !rx_empty;
    end

    always_comb begin
        reg_rdata = '0;
        if (rd_acc) begin
            if      (reg_addr == ADDR_W'(OFS_CTRL))   reg_rdata = ctrl_q;
            else if (reg_addr == ADDR_W'(OFS_FRAME))  reg_rdata = frame_q;
            else if (reg_addr == ADDR_W'(OFS_STAT))   reg_rdata = status;
            else if (reg_addr == ADDR_W'(OFS_CLKDIV)) reg_rdata = clkdiv_q;
            else if (reg_addr == ADDR_W'(OFS_RXD))    reg_rdata = rx_empty ? '0 : 32'(rx_head);
            else if (reg_addr == ADDR_W'(OFS_FLAG))   reg_rdata = flag_view;
            else if (reg_addr == ADDR_W'(OFS_FEN))    reg_rdata = ien_q;
        end
    end

    assert_rx_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rd_rxd) |=> $stable(rx_cnt));
    assert_txc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_txd |=> !txc_q);
    assert_tx_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_txoff |=> (!tx_en && !tx_avail));
    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && rx_empty) |-> reg_rdata == 32'd0);
endmodule

// File: tb/uart_regblk_test.sv
`timescale 1ns/1ps
module uart_regblk_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 0, reg_wr = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        rx_push = 0, tx_pop = 0, tx_done = 0;
    logic [8:0]  rx_char = 0;
    logic        tx_avail, rx_en, tx_en, irq_rx, irq_tx;
    logic [8:0]  tx_char;
    logic [31:0] cfg_ctrl, cfg_frame, cfg_clkdiv;

    always #2.5 clk = ~clk;

    uart_regblk uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_push(rx_push), .rx_char(rx_char), .tx_pop(tx_pop), .tx_done(tx_done),
        .tx_avail(tx_avail), .tx_char(tx_char), .rx_en(rx_en), .tx_en(tx_en),
        .cfg_ctrl(cfg_ctrl), .cfg_frame(cfg_frame), .cfg_clkdiv(cfg_clkdiv),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, got, exp);
        end
    endtask

    // behavioural reference model
    int        rxq[$];
    int        txq[$];
    bit        m_rx_on;
    int        m_txs;     // 0 off, 1 idle, 2 busy
    bit        m_txc;
    logic [31:0] m_flags, m_ien, m_ctrl, m_frame, m_clkdiv;

    function automatic bit m_lvl();
        return m_ctrl[12] ? (txq.size() < 2) : (txq.size() == 0);
    endfunction

    function automatic logic [31:0] m_flag_view();
        return m_flags | (32'(m_lvl()) << 1);
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] s;
        case (a)
            'h00: return m_ctrl;
            'h04: return m_frame;
            'h14: return m_clkdiv;
            'h10: begin
                s = 0;
                s[1] = (m_txs != 0);
                s[5] = m_txc;
                s[6] = m_lvl();
                s[7] = (rxq.size() > 0);
                return s;
            end
            'h18: return (rxq.size() > 0) ? 32'(rxq[0]) : 32'd0;
            'h40: return m_flag_view();
            'h4C: return m_ien;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(int a);
        case (a)
            'h00, 'h04, 'h14: return "R3";
            'h10: return "R8";
            'h18: return "R5";
            'h40: return "R9";
            'h4C: return "R10";
            'h0C: return "R2";
            default: return "R11";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rxq.delete(); txq.delete();
            m_rx_on = 0; m_txs = 0; m_txc = 0;
            m_flags = 0; m_ien = 0; m_ctrl = 0; m_frame = 0; m_clkdiv = 0;
        end else begin
            logic [31:0] cmd, ev;
            int rxs_old, txs_old;
            bit store, ovf, comp, wtx;
            cmd = (reg_sel && reg_wr && reg_addr == 8'h0C) ? reg_wdata : 32'd0;
            rxs_old = rxq.size();
            txs_old = txq.size();
            store = 0; ovf = 0; comp = 0;
            wtx = reg_sel && reg_wr && reg_addr == 8'h34;
            if (m_rx_on && rx_push) begin
                if (rxs_old == 2) ovf = 1; else store = 1;
            end
            if (reg_sel && !reg_wr && reg_addr == 8'h18 && rxs_old > 0) void'(rxq.pop_front());
            if (store) rxq.push_back(int'(rx_char));
            if (cmd[1]) m_rx_on = 0; else if (cmd[0]) m_rx_on = 1;
            if (cmd[3]) m_txs = 0;
            else begin
                case (m_txs)
                    0: if (cmd[2]) m_txs = 1;
                    1: if (tx_pop && txs_old > 0) begin void'(txq.pop_front()); m_txs = 2; end
                    default: if (tx_done) begin comp = (txs_old == 0); m_txs = 1; end
                endcase
            end
            if (wtx && txs_old < 2) txq.push_back(int'(reg_wdata[8:0]));
            if (wtx) m_txc = 0; else if (comp) m_txc = 1;
            ev = {27'd0, ovf, 1'b0, store, 1'b0, comp};
            if (reg_sel && reg_wr && reg_addr == 8'h44) m_flags |= reg_wdata & 32'h15;
            if (reg_sel && reg_wr && reg_addr == 8'h48) m_flags &= ~(reg_wdata & 32'h15);
            m_flags |= ev;
            if (reg_sel && reg_wr && reg_addr == 8'h4C) m_ien = reg_wdata;
            if (reg_sel && reg_wr && reg_addr == 8'h00) m_ctrl = reg_wdata;
            if (reg_sel && reg_wr && reg_addr == 8'h04) m_frame = reg_wdata;
            if (reg_sel && reg_wr && reg_addr == 8'h14) m_clkdiv = reg_wdata;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [31:0] fv;
            bit av;
            fv = m_flag_view();
            av = (m_txs == 1) && (txq.size() > 0);
            chk(reg_sel && !reg_wr ? rd_tag(int'(reg_addr)) : "R11", reg_rdata,
                (reg_sel && !reg_wr) ? m_read(int'(reg_addr)) : 32'd0);
            chk("R2", {31'd0, rx_en}, {31'd0, m_rx_on});
            chk("R2", {31'd0, tx_en}, {31'd0, m_txs != 0});
            chk("R10", {31'd0, irq_rx}, {31'd0, |(fv & m_ien & 32'h14)});
            chk("R10", {31'd0, irq_tx}, {31'd0, |(fv & m_ien & 32'h03)});
            chk("R7", {31'd0, tx_avail}, {31'd0, av});
            if (av) chk("R7", 32'(tx_char), 32'(txq[0]));
            chk("R3", cfg_ctrl, m_ctrl);
            chk("R3", cfg_frame, m_frame);
            chk("R3", cfg_clkdiv, m_clkdiv);
        end
    end

    task automatic step(bit s, bit w, logic [7:0] a, logic [31:0] d,
                        bit rp, logic [8:0] rc, bit tp, bit td);
        @(posedge clk); #1;
        reg_sel = s; reg_wr = w; reg_addr = a; reg_wdata = d;
        rx_push = rp; rx_char = rc; tx_pop = tp; tx_done = td;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        step(1, 1, a, d, 0, 0, 0, 0);
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        step(1, 0, a, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pin(string tag, logic got, logic exp);
        @(negedge clk);
        chk(tag, {31'd0, got}, {31'd0, exp});
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            total++; bad++;
            $display("FAIL R7 watchdog: actual=%0d expected<150000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle();
        // R1 reset state
        rd(8'h10, 32'h40, "R1");
        rd(8'h40, 32'h02, "R1");
        pin("R1", rx_en, 1'b0);
        pin("R1", tx_en, 1'b0);
        // R3 configuration words
        wr(8'h04, 32'hA5A5_1005);
        wr(8'h14, 32'h0000_1240);
        rd(8'h04, 32'hA5A5_1005, "R3");
        rd(8'h14, 32'h0000_1240, "R3");
        // R10 enable word
        wr(8'h4C, 32'h17);
        rd(8'h4C, 32'h17, "R10");
        // R2 receiver on
        wr(8'h0C, 32'h1);
        idle();
        pin("R2", rx_en, 1'b1);
        // R4 receive and overflow
        step(0, 0, 0, 0, 1, 9'h041, 0, 0);
        step(0, 0, 0, 0, 1, 9'h1A5, 0, 0);
        idle();
        pin("R10", irq_rx, 1'b1);
        rd(8'h10, 32'hC0, "R5");
        step(0, 0, 0, 0, 1, 9'h0FF, 0, 0);
        idle();
        rd(8'h40, 32'h16, "R4");
        rd(8'h18, 32'h041, "R5");
        rd(8'h18, 32'h1A5, "R5");
        rd(8'h18, 32'h0, "R5");
        rd(8'h10, 32'h40, "R5");
        wr(8'h48, 32'h14);
        idle();
        pin("R9", irq_rx, 1'b0);
        // R4 receiver off ignores pushes
        wr(8'h0C, 32'h2);
        step(0, 0, 0, 0, 1, 9'h033, 0, 0);
        idle();
        rd(8'h10, 32'h40, "R4");
        rd(8'h40, 32'h02, "R4");
        // R2 off wins over on
        wr(8'h0C, 32'h3);
        idle();
        pin("R2", rx_en, 1'b0);
        rd(8'h0C, 32'h0, "R2");
        wr(8'h0C, 32'h5);
        idle();
        pin("R2", tx_en, 1'b1);
        rd(8'h10, 32'h42, "R2");
        // R6 transmit buffer fill and drop
        wr(8'h34, 32'h55);
        wr(8'h34, 32'h66);
        wr(8'h34, 32'h77);
        idle();
        rd(8'h10, 32'h02, "R6");
        pin("R7", tx_avail, 1'b1);
        pin("R10", irq_tx, 1'b0);
        // R7 serving frames
        step(0, 0, 0, 0, 0, 0, 1, 0);
        idle();
        pin("R7", tx_avail, 1'b0);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        idle();
        chk("R7", 32'(tx_char), 32'h66);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        idle();
        rd(8'h10, 32'h62, "R7");
        rd(8'h40, 32'h03, "R7");
        pin("R10", irq_tx, 1'b1);
        wr(8'h48, 32'h1);
        wr(8'h34, 32'h12);
        idle();
        rd(8'h10, 32'h02, "R6");
        // R8 threshold select and no software control of level flag
        wr(8'h00, 32'h1000);
        idle();
        rd(8'h10, 32'h42, "R8");
        wr(8'h48, 32'h2);
        rd(8'h40, 32'h02, "R8");
        wr(8'h00, 32'h0);
        wr(8'h44, 32'h2);
        rd(8'h40, 32'h00, "R8");
        // R7 disable while busy
        step(0, 0, 0, 0, 0, 0, 1, 0);
        wr(8'h0C, 32'h8);
        idle();
        pin("R7", tx_en, 1'b0);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        idle();
        rd(8'h10, 32'h40, "R7");
        // R9 set and clear
        wr(8'h44, 32'h15);
        rd(8'h40, 32'h17, "R9");
        wr(8'h48, 32'h04);
        rd(8'h40, 32'h13, "R9");
        rd(8'h44, 32'h0, "R9");
        wr(8'h0C, 32'h1);
        step(1, 1, 8'h48, 32'h04, 1, 9'h05A, 0, 0);
        idle();
        rd(8'h40, 32'h17, "R9");
        // R11 unmapped
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0, "R11");
        rd(8'h04, 32'hA5A5_1005, "R11");
        // mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] addrs [12];
            logic [31:0] d;
            int k;
            addrs = '{8'h00, 8'h04, 8'h0C, 8'h10, 8'h14, 8'h18,
                      8'h34, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h24};
            k = int'($urandom_range(0, 11));
            d = $urandom;
            if (addrs[k] == 8'h0C) d = d & 32'hF;
            step(($urandom_range(0, 2) != 0), $urandom_range(0, 1), addrs[k], d,
                 $urandom_range(0, 1), 9'($urandom), $urandom_range(0, 1),
                 $urandom_range(0, 1));
        end
        idle();
        @(negedge clk);
        finish_run();
    end
endmodule